// File: doc/BRIEF.md
# Summed-Delay PUF Response Evaluator

This block forms one response of a 64-stage summed-delay physical unclonable function. Each stage is a pair of ring oscillators, and each oscillator is measured as an unsigned delay count. Per stage, one challenge bit picks which count of the pair joins the upper delay sum and which joins the lower one. Once every stage has been folded in, the block presents the signed difference between the upper and lower sums. It also presents a response bit taken from the sign of that difference and a confidence magnitude equal to its absolute value. Downstream index-based key coding can then pick the strongest or weakest responses instead of relying on a bare bit.

A one-cycle start pulse latches the full challenge vector and clears the running sum. The stage pairs then arrive in stage order, one per cycle whenever the valid input is high, and gaps between pairs are allowed. After the last pair a single-cycle done pulse marks the result. The result stays on the outputs until the next start. The oscillators and frequency counters sit outside the block.

Top module: `puf_sum_eval`

## Requirements
- R1: After reset, busy_o and done_o are 0 and diff_o is 0.
- R2: A start pulse captures challenge_i. Later changes of challenge_i have no effect on that evaluation.
- R3: The k-th pair accepted after a start belongs to stage k (k = 0..63) and uses challenge bit k. Bit value 0 sends cnt_a_i to the upper sum and cnt_b_i to the lower sum. Bit value 1 swaps them. diff_o equals the upper sum minus the lower sum.
- R4: A pair is accepted only in a cycle where pair_valid_i is high and an evaluation is in progress. Cycles with pair_valid_i low add nothing, whatever the count inputs carry.
- R5: resp_o is 1 when diff_o is zero or positive, and 0 when diff_o is negative.
- R6: conf_o is the absolute value of diff_o, 22 bits wide.
- R7: The 23-bit signed difference never wraps. With all counts at 65535 on one side and 0 on the other, it reads exactly +4194240 or -4194240.
- R8: done_o is high for exactly one cycle, in the cycle right after the 64th pair is accepted. busy_o falls at the same edge, and done_o stays low while earlier pairs are taken.
- R9: After done, diff_o, resp_o and conf_o hold their values until the next start. Pairs presented while idle are ignored.
- R10: A start during an evaluation restarts it from a zero sum at stage 0 with the new challenge. A pair presented in the same cycle as start is discarded.
- R11: When start coincides with the 64th pair, the restart wins. No done pulse follows, and busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new evaluation and capture the challenge |
| challenge_i | input | 64 | One selection bit per stage |
| pair_valid_i | input | 1 | Stage pair present on cnt_a_i / cnt_b_i |
| cnt_a_i | input | 16 | First delay count of the current stage |
| cnt_b_i | input | 16 | Second delay count of the current stage |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse: result complete |
| diff_o | output | 23 | Signed difference, upper minus lower |
| resp_o | output | 1 | Response bit, 1 for a non-negative difference |
| conf_o | output | 22 | Confidence, absolute value of the difference |

## Verification
A restart and the completion of a run can land on the same clock edge: start_i may arrive together with the final stage pair, or together with any earlier pair. The bench drives these collisions on purpose. It feeds 63 pairs, then raises start with the 64th. It also restarts after ten pairs with a pair present in the same cycle. In both cases it expects no done pulse, busy still high and a zero sum in the following cycle. It then runs a complete fresh evaluation and checks that the result equals the new data alone.

// File: rtl/puf_eval_pkg.sv
package puf_eval_pkg;
  // sum of n differences of w-bit unsigned counts, plus sign
  function automatic int unsigned diff_width(int unsigned n, int unsigned w);
    return w + $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/puf_stage_route.sv
module puf_stage_route #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                    swap_i,
  input  logic [CNT_W-1:0]        cnt_a_i,
  input  logic [CNT_W-1:0]        cnt_b_i,
  output logic signed [CNT_W:0]   delta_o
);
  logic signed [CNT_W:0] a_s, b_s;
  assign a_s = $signed({1'b0, cnt_a_i});
  assign b_s = $signed({1'b0, cnt_b_i});
  // contribution to (upper - lower)
  assign delta_o = swap_i ? (b_s - a_s) : (a_s - b_s);
endmodule

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl #(
  parameter int unsigned N_STAGES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N_STAGES-1:0] chal_i,
  input  logic                valid_i,
  output logic                busy_o,
  output logic                accept_o,
  output logic                clear_o,
  output logic                swap_o,
  output logic                done_o
);
  localparam int unsigned IDX_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STAGES - 1);

  logic [N_STAGES-1:0] chal_q;
  logic [IDX_W-1:0]    idx_q;
  logic                busy_q, done_q;
  logic                last_stage;

  assign last_stage = (idx_q == LAST_IDX);
  assign clear_o    = start_i;
  assign accept_o   = busy_q & valid_i & ~start_i;
  assign swap_o     = chal_q[idx_q];
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chal_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      chal_q <= chal_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        if (last_stage) begin
          idx_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (!busy_q && $past(busy_q) && $past(valid_i))); // R8
  AST_START_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && !done_q)); // R11
endmodule

// File: rtl/puf_diff_acc.sv
module puf_diff_acc #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIFF_W = 23
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     add_i,
  input  logic signed [CNT_W:0]    delta_i,
  output logic signed [DIFF_W-1:0] acc_o
);
  logic signed [DIFF_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + DIFF_W'(delta_i);
  end

  assign acc_o = acc_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_i && !clear_i) |=> $stable(acc_q)); // R9
endmodule

// File: rtl/puf_sum_eval.sv
module puf_sum_eval
  import puf_eval_pkg::*;
#(
  parameter int unsigned N_STAGES = 64,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIFF_W   = diff_width(N_STAGES, CNT_W),
  parameter int unsigned CONF_W   = DIFF_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N_STAGES-1:0] challenge_i,
  input  logic                pair_valid_i,
  input  logic [CNT_W-1:0]    cnt_a_i,
  input  logic [CNT_W-1:0]    cnt_b_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DIFF_W-1:0]   diff_o,
  output logic                resp_o,
  output logic [CONF_W-1:0]   conf_o
);
  logic                     accept, clear, swap;
  logic signed [CNT_W:0]    delta;
  logic signed [DIFF_W-1:0] acc;
  logic [DIFF_W-1:0]        mag;

  puf_seq_ctrl #(.N_STAGES(N_STAGES)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .chal_i  (challenge_i),
    .valid_i (pair_valid_i),
    .busy_o  (busy_o),
    .accept_o(accept),
    .clear_o (clear),
    .swap_o  (swap),
    .done_o  (done_o)
  );

  puf_stage_route #(.CNT_W(CNT_W)) i_route (
    .swap_i (swap),
    .cnt_a_i(cnt_a_i),
    .cnt_b_i(cnt_b_i),
    .delta_o(delta)
  );

  puf_diff_acc #(.CNT_W(CNT_W), .DIFF_W(DIFF_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .add_i  (accept),
    .delta_i(delta),
    .acc_o  (acc)
  );

  assign mag    = acc[DIFF_W-1] ? DIFF_W'(-acc) : DIFF_W'(acc);
  assign diff_o = acc;
  assign resp_o = ~acc[DIFF_W-1];
  assign conf_o = mag[CONF_W-1:0];

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(diff_o)); // R9
  AST_CONF_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mag[DIFF_W-1] == 1'b0)); // R7
endmodule

// File: tb/test_puf_sum_eval.sv
module test_puf_sum_eval;
  localparam int N = 64;

  logic              clk = 0, rst_n = 0;
  logic              start = 0, valid = 0;
  logic [N-1:0]      chal = '0;
  logic [15:0]       ca = '0, cb = '0;
  logic              busy, done, resp;
  logic signed [22:0] diff;
  logic [21:0]       conf;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] pa[N], pb[N];

  always #5 clk = ~clk;

  puf_sum_eval i_puf_sum_eval (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .challenge_i(chal),
    .pair_valid_i(valid), .cnt_a_i(ca), .cnt_b_i(cb),
    .busy_o(busy), .done_o(done), .diff_o(diff), .resp_o(resp), .conf_o(conf)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [N-1:0] c);
    int s = 0;
    for (int i = 0; i < N; i++)
      s += c[i] ? (int'(pb[i]) - int'(pa[i])) : (int'(pa[i]) - int'(pb[i]));
    return s;
  endfunction

  task automatic fill_rand();
    for (int i = 0; i < N; i++) begin pa[i] = 16'($urandom); pb[i] = 16'($urandom); end
  endtask

  task automatic do_start(input logic [N-1:0] c);
    @(negedge clk); start = 1; chal = c; valid = 0;
    @(negedge clk); start = 0; chal = {$urandom, $urandom}; // R2 scramble after capture
  endtask

  task automatic feed(input int n, input bit gaps);
    bit early = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        valid = 0; ca = 16'($urandom); cb = 16'($urandom);
        repeat (1 + $urandom % 3) @(negedge clk);
      end
      if (done) early = 1;
      valid = 1; ca = pa[i]; cb = pb[i];
      @(negedge clk);
    end
    valid = 0;
    check(!early, "R8 no early done", early, 0);
  endtask

  task automatic check_result(input int exp, input string tag);
    int mag = exp < 0 ? -exp : exp;
    check(done == 1 && busy == 0, {"R8 done pulse ", tag}, done, 1);
    check(int'(diff) == exp, {"R3 diff ", tag}, diff, exp);
    check(resp == (exp >= 0), {"R5 resp ", tag}, resp, exp >= 0);
    check(int'(conf) == mag, {"R6 conf ", tag}, conf, mag);
    @(negedge clk);
    check(done == 0, {"R8 single cycle ", tag}, done, 0);
  endtask

  task automatic run(input logic [N-1:0] c, input bit gaps, input string tag);
    int exp;
    do_start(c);
    feed(N, gaps);
    exp = model(c);
    check_result(exp, tag);
    // R9: idle pairs ignored, outputs held
    valid = 1;
    repeat (3) begin ca = 16'($urandom); cb = 16'($urandom); @(negedge clk); end
    valid = 0;
    @(negedge clk);
    check(int'(diff) == exp && done == 0 && busy == 0, {"R9 hold ", tag}, diff, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] c1, c2;
    int exp;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && diff == 0, "R1 reset state", diff, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && diff == 0, "R1 after release", diff, 0);

    // random runs, R2/R3/R4 with gaps and scrambled challenge
    for (int r = 0; r < 6; r++) begin
      fill_rand();
      run({$urandom, $urandom}, r[0], "random");
    end

    // R7 extremes
    for (int i = 0; i < N; i++) begin pa[i] = 16'hFFFF; pb[i] = 16'h0; end
    run('0, 0, "R7 max positive");
    run('1, 1, "R7 max negative");
    check(model('1) == -4194240, "R7 model bound", model('1), -4194240);

    // R5 zero boundary
    for (int i = 0; i < N; i++) begin pa[i] = 16'(i * 7); pb[i] = 16'(i * 7); end
    run({$urandom, $urandom}, 0, "R5 zero diff");

    // R10: restart mid-run with a pair in the start cycle
    fill_rand();
    do_start({$urandom, $urandom});
    feed(10, 0);
    c2 = {$urandom, $urandom};
    @(negedge clk); start = 1; chal = c2; valid = 1; ca = 16'hFFFF; cb = 16'h0;
    @(negedge clk); start = 0; valid = 0;
    check(busy == 1 && done == 0 && diff == 0, "R10 restart clears", diff, 0);
    fill_rand();
    feed(N, 1);
    exp = model(c2);
    check_result(exp, "R10 after restart");

    // R11: start collides with the 64th pair
    fill_rand();
    c1 = {$urandom, $urandom};
    do_start(c1);
    feed(N - 1, 0);
    c2 = {$urandom, $urandom};
    start = 1; chal = c2; valid = 1; ca = pa[N-1]; cb = pb[N-1];
    @(negedge clk); start = 0; valid = 0;
    check(done == 0 && busy == 1 && diff == 0, "R11 collision no done", done, 0);
    fill_rand();
    feed(N, 0);
    exp = model(c2);
    check_result(exp, "R11 after collision");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule